// File: doc/BRIEF.md
# Guest Page-Base Write Filter

This block decides, for each guest attempt to write the page-table base register, whether the write may proceed inside the guest or must trap to the hypervisor. It keeps a small table of permitted base values together with a count register. Only the first *count* table entries take part in matching. A write whose value equals one of those entries is allowed. Every other write traps.

The hypervisor loads the table and the count through a plain address/data/write-enable port. An entry-time validity output goes low when the programmed count exceeds the number of slots, so the entry path can refuse to start the guest. While that flag is low, every request traps.

Each request is a one-cycle valid pulse carrying the candidate value. The exit/no-exit answer comes back on a valid strobe exactly one cycle later. The number of implemented slots is available as a constant output so software can discover it. The slot width is chosen by a parameter: 64 bits in the wide-address configuration and 32 bits otherwise. The count is always 32 bits.

Top module: `pgbase_write_filter`

## Requirements
- R1: After reset, every slot and the count hold 0, `entry_ok` is 1 and `rsp_valid` is 0, so a request for value 0 returns `rsp_exit`=1.
- R2: A config write loads a slot when `cfg_addr` is 0..3, with address k selecting slot k, and loads the count when `cfg_addr` is 4. Any bit pattern is accepted into a slot. A load takes effect from the next clock edge, so a request made in the same cycle as a load still sees the old contents.
- R3: A request whose value equals slot k, where k is below the count, returns `rsp_exit`=0.
- R4: Slots whose index is equal to or greater than the count are ignored during matching, even when they hold the requested value.
- R5: When the count is 0, every request returns `rsp_exit`=1.
- R6: `entry_ok` is 0 exactly when the count, read as an unsigned 32-bit number, is greater than 4.
- R7: While `entry_ok` is 0, every request returns `rsp_exit`=1.
- R8: `rsp_valid` is 1 in exactly the cycle after each cycle in which `req_valid` is 1, and 0 otherwise.
- R9: `slots_supported` always reads 4.
- R10: A count load keeps only bits [31:0] of `cfg_wdata`. The upper bits of the wide configuration are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Config write enable |
| cfg_addr | input | 3 | Config address: 0..3 select a slot, 4 selects the count |
| cfg_wdata | input | VAL_W (64) | Config write data |
| req_valid | input | 1 | Request strobe |
| req_value | input | VAL_W (64) | Candidate base value |
| rsp_valid | output | 1 | Decision strobe, one cycle after the request |
| rsp_exit | output | 1 | 1 = trap to the hypervisor, 0 = allow |
| entry_ok | output | 1 | 0 when the programmed count is illegal |
| slots_supported | output | 32 | Constant number of implemented slots |

## Verification
The hardest case to reach from the ports is a slot that holds exactly the requested value but lies at or above the count. The bench fills every slot with distinct values, then lowers the count step by step and repeats requests for the slots that have dropped out of range. A second awkward case is a request issued in the same cycle as a count load. The bench drives both on the same falling edge and expects the old count to decide. Illegal counts are exercised just above the limit and at the all-ones value. A load with the upper data bits set confirms that only the low 32 bits reach the count.

// File: rtl/pgf_pkg.sv
package pgf_pkg;
  localparam int unsigned SLOTS   = 4;
  localparam int unsigned CNT_W   = 32;
  localparam int unsigned ADDR_W  = 3;
  localparam logic [ADDR_W-1:0] CNT_ADDR = 3'd4;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/pgf_rst_sync.sv
module pgf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pgf_target_table.sv
module pgf_target_table
  import pgf_pkg::*;
#(
  parameter int unsigned VAL_W = 64,
  parameter int unsigned NUM   = SLOTS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [VAL_W-1:0]           cfg_wdata,
  output logic [NUM-1:0][VAL_W-1:0]  slot_q,
  output cnt_t                       cnt_q,
  output logic                       entry_ok
);
  localparam cnt_t NUM_C = CNT_W'(NUM);

  logic [NUM-1:0]            slot_en;
  logic [NUM-1:0][VAL_W-1:0] slot_d;
  logic                      cnt_en;
  cnt_t                      cnt_d;

  for (genvar i = 0; i < NUM; i++) begin : g_slot
    always_comb begin
      slot_en[i] = cfg_we && (cfg_addr == ADDR_W'(i));
      slot_d[i]  = cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          slot_q[i] <= '0;
      else if (slot_en[i]) slot_q[i] <= slot_d[i];
    end

    assert_slot_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == ADDR_W'(i)) |=> (slot_q[i] == $past(cfg_wdata)));
  end

  always_comb begin
    cnt_en = cfg_we && (cfg_addr == CNT_ADDR);
    cnt_d  = cfg_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign entry_ok = (cnt_q <= NUM_C);

  assert_count_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == CNT_ADDR) |=> (cnt_q == $past(cfg_wdata[CNT_W-1:0])));

  assert_big_count_fails_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == CNT_ADDR && cfg_wdata[CNT_W-1:0] > NUM_C) |=> !entry_ok);
endmodule

// File: rtl/pgf_match.sv
module pgf_match
  import pgf_pkg::*;
#(
  parameter int unsigned VAL_W = 64,
  parameter int unsigned NUM   = SLOTS
) (
  input  logic [NUM-1:0][VAL_W-1:0] slot_q,
  input  cnt_t                      cnt_q,
  input  logic [VAL_W-1:0]          value,
  output logic                      hit
);
  logic [NUM-1:0] eq_vec;
  logic [NUM-1:0] live_vec;

  for (genvar i = 0; i < NUM; i++) begin : g_cmp
    always_comb begin
      eq_vec[i]   = (slot_q[i] == value);
      live_vec[i] = (cnt_q > CNT_W'(i));
    end
  end

  assign hit = |(eq_vec & live_vec);
endmodule

// File: rtl/pgf_decide.sv
module pgf_decide (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic hit,
  input  logic entry_ok,
  output logic rsp_valid,
  output logic rsp_exit
);
  logic exit_d;
  logic valid_d;

  always_comb begin
    valid_d = req_valid;
    exit_d  = !(hit && entry_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rsp_exit <= 1'b1;
    else if (req_valid) rsp_exit <= exit_d;
  end

  assert_rsp_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_spurious_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_bad_entry_exits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !entry_ok) |=> rsp_exit);
endmodule

// File: rtl/pgbase_write_filter.sv
module pgbase_write_filter
  import pgf_pkg::*;
#(
  parameter bit          WIDE  = 1'b1,
  parameter int unsigned VAL_W = WIDE ? 64 : 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [VAL_W-1:0]    cfg_wdata,
  input  logic                req_valid,
  input  logic [VAL_W-1:0]    req_value,
  output logic                rsp_valid,
  output logic                rsp_exit,
  output logic                entry_ok,
  output logic [CNT_W-1:0]    slots_supported
);
  logic                        rst_sync_n;
  logic [SLOTS-1:0][VAL_W-1:0] slot_q;
  cnt_t                        cnt_q;
  logic                        hit;

  assign slots_supported = CNT_W'(SLOTS);

  pgf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pgf_target_table #(.VAL_W(VAL_W), .NUM(SLOTS)) u_table (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .slot_q    (slot_q),
    .cnt_q     (cnt_q),
    .entry_ok  (entry_ok)
  );

  pgf_match #(.VAL_W(VAL_W), .NUM(SLOTS)) u_match (
    .slot_q (slot_q),
    .cnt_q  (cnt_q),
    .value  (req_value),
    .hit    (hit)
  );

  pgf_decide u_decide (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .hit       (hit),
    .entry_ok  (entry_ok),
    .rsp_valid (rsp_valid),
    .rsp_exit  (rsp_exit)
  );

  assert_zero_count_exits_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && cnt_q == '0) |=> rsp_exit);
endmodule

// File: tb/pgbase_write_filter_test.sv
module pgbase_write_filter_test;
  localparam int VW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [VW-1:0] cfg_wdata = '0;
  logic          req_valid = 1'b0;
  logic [VW-1:0] req_value = '0;
  logic          rsp_valid, rsp_exit, entry_ok;
  logic [31:0]   slots_supported;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  localparam logic [VW-1:0] VA = 64'h0000_0001_0000_1000;
  localparam logic [VW-1:0] VB = 64'h0000_0002_0000_2000;
  localparam logic [VW-1:0] VC = 64'h0000_0003_0000_3000;
  localparam logic [VW-1:0] VD = 64'h0000_0004_0000_4000;

  always #2 clk = ~clk;

  pgbase_write_filter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_value(req_value),
    .rsp_valid(rsp_valid), .rsp_exit(rsp_exit), .entry_ok(entry_ok),
    .slots_supported(slots_supported)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [VW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic request(input string tag, input logic [VW-1:0] v, input logic exp_exit);
    @(negedge clk);
    req_valid = 1'b1; req_value = v;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, 64'(rsp_valid), 64'd1);
    check(tag, 64'(rsp_exit), 64'(exp_exit));
  endtask

  task automatic t_reset;
    check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check("R1 entry_ok after reset", 64'(entry_ok), 64'd1);
    check("R9 slots_supported", 64'(slots_supported), 64'd4);
    request("R1 value 0 after reset", '0, 1'b1);
  endtask

  task automatic t_match;
    cfg_write(3'd0, VA); cfg_write(3'd1, VB);
    cfg_write(3'd2, VC); cfg_write(3'd3, VD);
    cfg_write(3'd4, 64'd4);
    request("R3 slot0", VA, 1'b0);
    request("R3 slot1", VB, 1'b0);
    request("R3 slot2", VC, 1'b0);
    request("R3 slot3", VD, 1'b0);
    request("R3 miss", 64'h1234, 1'b1);
  endtask

  task automatic t_limit;
    cfg_write(3'd4, 64'd2);
    request("R4 slot2 beyond count 2", VC, 1'b1);
    request("R4 slot3 beyond count 2", VD, 1'b1);
    request("R3 slot1 within count 2", VB, 1'b0);
    cfg_write(3'd4, 64'd1);
    request("R4 slot1 beyond count 1", VB, 1'b1);
    request("R3 slot0 within count 1", VA, 1'b0);
  endtask

  task automatic t_zero;
    cfg_write(3'd4, 64'd0);
    request("R5 count 0 slot0", VA, 1'b1);
    request("R5 count 0 slot3", VD, 1'b1);
  endtask

  task automatic t_entry;
    cfg_write(3'd4, 64'd5);
    check("R6 count 5 entry_ok", 64'(entry_ok), 64'd0);
    request("R7 bad entry slot0", VA, 1'b1);
    cfg_write(3'd4, 64'd4);
    check("R6 count 4 entry_ok", 64'(entry_ok), 64'd1);
    cfg_write(3'd4, 64'hFFFF_FFFF);
    check("R6 count all-ones entry_ok", 64'(entry_ok), 64'd0);
    request("R7 all-ones count slot1", VB, 1'b1);
    cfg_write(3'd4, 64'hFFFF_FFFF_0000_0003);
    check("R10 upper bits dropped entry_ok", 64'(entry_ok), 64'd1);
    request("R10 count 3 slot2 hits", VC, 1'b0);
    request("R10 count 3 slot3 beyond", VD, 1'b1);
  endtask

  task automatic t_anyval;
    cfg_write(3'd0, '1);
    cfg_write(3'd1, '0);
    cfg_write(3'd4, 64'd2);
    request("R2 all-ones slot value", '1, 1'b0);
    request("R2 zero slot value", '0, 1'b0);
  endtask

  task automatic t_timing;
    cfg_write(3'd4, 64'd0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = 64'd4;
    req_valid = 1'b1; req_value = VC;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R2 same-cycle load uses old count", 64'(rsp_exit), 64'd1);
    @(negedge clk);
    check("R8 no response without request", 64'(rsp_valid), 64'd0);
    req_valid = 1'b1; req_value = VC;
    @(negedge clk);
    req_value = 64'h55;
    check("R8 back-to-back first valid", 64'(rsp_valid), 64'd1);
    check("R2 new count applied", 64'(rsp_exit), 64'd0);
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 back-to-back second valid", 64'(rsp_valid), 64'd1);
    check("R3 back-to-back second miss", 64'(rsp_exit), 64'd1);
    @(negedge clk);
    check("R8 strobe drops", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_match();
    t_limit();
    t_zero();
    t_entry();
    t_anyval();
    t_timing();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule